// File: doc/BRIEF.md
# Trace Source Merger with Held Round-Robin Grant

This block joins up to eight byte-wide trace streams into one outgoing stream. Each incoming stream is a valid/ready channel. The merged output carries every accepted byte together with the 3-bit number of the port it came from, so a downstream consumer can separate the streams again. A rotating arbiter serves only the ports that are switched on. It stays on a granted port for a programmable number of beats before it moves on. This keeps short bursts from one source together.

Software sets the block up through a small word-addressed register interface. A control word holds the per-port enable mask and the hold length. A separate lock register guards the control word. Control writes take effect only after a 32-bit key has been written to the lock register. Any other value written there closes it again. The output is a combinational path from the selected input, so the block holds no beat internally. A change of enable mask can stop a port, but it cannot lose or repeat a beat.

Top module: `trace_merge`

## Requirements
- R1: After reset the block is locked, every port is disabled, and a read of the control word at address 0x000 returns 0x0000_0300.
- R2: While locked, writes to the control word leave it unchanged, and reads still return its current value.
- R3: Writing 0xC5ACCE55 to address 0xFB0 unlocks the block. Writing any other value to that address locks it again.
- R4: In the control word, bits [7:0] are the enable mask (bit n switches on port n) and bits [11:8] are the hold field. Reads at any other address return zero.
- R5: A port whose enable bit is clear never receives ready and never appears on the output.
- R6: While other enabled ports are waiting, a granted port keeps the grant for hold field + 1 beats and then loses it. A hold field of 0 gives one beat per grant.
- R7: A new grant goes to the lowest-numbered enabled port with valid data above the previously granted index, wrapping from port 7 to port 0. After reset the search starts at port 0.
- R8: The arbiter moves on without waiting out the hold count when the granted port has no valid data or its enable bit has been cleared.
- R9: Each output beat carries the data byte of the selected port, and that port's index on the 3-bit source output.
- R10: At most one port sees ready, and only when the output is taken. While the output is stalled, the offered port and byte stay the same. Each accepted beat leaves the output exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 8 | Per-port valid |
| inData | input | 64 | Per-port byte, port n in bits [8n+7:8n] |
| inReady | output | 8 | Per-port ready |
| outValid | output | 1 | Merged stream valid |
| outData | output | 8 | Merged stream byte |
| outSrc | output | 3 | Source port index of the current beat |
| outReady | input | 1 | Merged stream ready |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on regAddr) |

## Verification
The bound checker watches a fixed set of properties on every cycle:
- ready reaches at most one port, and only an enabled one;
- every accepted beat comes from a valid, ready port;
- a stalled offer stays the same;
- a control write made while locked does not change the control word.

The hold length, the rotation order with wrap, the early switch, the key handling and the reset value all depend on sequences of traffic and register writes. Only the bench's directed scenarios can show these. The bench compares each cycle against its own arbitration model.

// File: rtl/tm_pkg.sv
package tm_pkg;
  parameter int unsigned TM_ID_W = 3;

  // Strobes from the arbiter to the datapath
  typedef struct packed {
    logic               selValid;
    logic [TM_ID_W-1:0] selIdx;
  } tm_sel_t;
endpackage

// File: rtl/tm_regs.sv
module tm_regs #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned HOLD_W    = 4,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned REG_W     = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h000,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 12'hFB0,
  parameter logic [REG_W-1:0]  KEY      = 32'hC5ACCE55,
  parameter logic [HOLD_W-1:0] HOLD_RST = 4'h3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  output logic [NUM_PORTS-1:0] ctrlMask,
  output logic [HOLD_W-1:0]    ctrlHold,
  output logic [REG_W-1:0]     ctrlWord,
  output logic                 locked
);
  localparam int unsigned HOLD_LSB = 8;

  logic ctrlWrite;
  logic lockWrite;

  assign ctrlWrite = regWrEn && (regAddr == CTRL_ADDR) && !locked;
  assign lockWrite = regWrEn && (regAddr == LOCK_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked   <= 1'b1;
      ctrlMask <= '0;
      ctrlHold <= HOLD_RST;
    end else begin
      if (lockWrite) locked <= (regWrData != KEY);
      if (ctrlWrite) begin
        ctrlMask <= regWrData[NUM_PORTS-1:0];
        ctrlHold <= regWrData[HOLD_LSB +: HOLD_W];
      end
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[NUM_PORTS-1:0]       = ctrlMask;
    ctrlWord[HOLD_LSB +: HOLD_W]  = ctrlHold;
  end

  assign regRdData = (regAddr == CTRL_ADDR) ? ctrlWord : '0;
endmodule

// File: rtl/tm_arb.sv
module tm_arb
  import tm_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned HOLD_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] eligible,
  input  logic [HOLD_W-1:0]    holdField,
  input  logic                 fire,
  output tm_sel_t              sel
);
  localparam int unsigned ID_W  = TM_ID_W;
  localparam int unsigned CNT_W = HOLD_W + 1;

  logic [ID_W-1:0]  curIdx;
  logic             active;
  logic [CNT_W-1:0] beatCnt;
  logic             keep;
  logic [ID_W-1:0]  nextIdx;
  logic             anyElig;
  logic [ID_W-1:0]  pick;
  logic [CNT_W-1:0] newCnt;
  logic             holdDone;

  // Search upward from the last granted index, wrapping
  always_comb begin
    logic found;
    found   = 1'b0;
    nextIdx = curIdx;
    for (int unsigned k = 1; k <= NUM_PORTS; k++) begin
      int unsigned idx;
      idx = (int'(curIdx) + k) % NUM_PORTS;
      if (!found && eligible[idx]) begin
        found   = 1'b1;
        nextIdx = ID_W'(idx);
      end
    end
  end

  assign anyElig  = |eligible;
  assign keep     = active && eligible[curIdx];
  assign pick     = keep ? curIdx : nextIdx;
  assign newCnt   = (keep ? beatCnt : '0) + 1'b1;
  assign holdDone = (newCnt == ({1'b0, holdField} + 1'b1));

  assign sel.selValid = keep || anyElig;
  assign sel.selIdx   = pick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx  <= ID_W'(NUM_PORTS - 1);
      active  <= 1'b0;
      beatCnt <= '0;
    end else if (fire) begin
      curIdx <= pick;
      if (holdDone) begin
        active  <= 1'b0;
        beatCnt <= '0;
      end else begin
        active  <= 1'b1;
        beatCnt <= newCnt;
      end
    end else if (sel.selValid) begin
      curIdx <= pick;
      active <= 1'b1;
      if (!keep) beatCnt <= '0;
    end else begin
      active  <= 1'b0;
      beatCnt <= '0;
    end
  end
endmodule

// File: rtl/tm_path.sv
module tm_path
  import tm_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned DATA_W    = 8
) (
  input  tm_sel_t                     sel,
  input  logic [NUM_PORTS*DATA_W-1:0] inData,
  input  logic                        outReady,
  output logic [NUM_PORTS-1:0]        inReady,
  output logic                        outValid,
  output logic [DATA_W-1:0]           outData,
  output logic [TM_ID_W-1:0]          outSrc,
  output logic                        fire
);
  genvar g;
  generate
    for (g = 0; g < NUM_PORTS; g++) begin : g_ready
      assign inReady[g] = sel.selValid && outReady && (sel.selIdx == TM_ID_W'(g));
    end
  endgenerate

  assign outValid = sel.selValid;
  assign outSrc   = sel.selIdx;
  assign outData  = inData[sel.selIdx*DATA_W +: DATA_W];
  assign fire     = sel.selValid && outReady;
endmodule

// File: rtl/trace_merge.sv
module trace_merge
  import tm_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned HOLD_W    = 4,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned REG_W     = 32,
  parameter int unsigned ID_W      = TM_ID_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS-1:0]        inValid,
  input  logic [NUM_PORTS*DATA_W-1:0] inData,
  output logic [NUM_PORTS-1:0]        inReady,
  output logic                        outValid,
  output logic [DATA_W-1:0]           outData,
  output logic [ID_W-1:0]             outSrc,
  input  logic                        outReady,
  input  logic                        regWrEn,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [REG_W-1:0]            regWrData,
  output logic [REG_W-1:0]            regRdData
);
  logic [NUM_PORTS-1:0] ctrlMask;
  logic [HOLD_W-1:0]    ctrlHold;
  logic [REG_W-1:0]     ctrlWord;
  logic                 locked;
  logic                 fire;
  tm_sel_t              sel;

  tm_regs #(.NUM_PORTS(NUM_PORTS), .HOLD_W(HOLD_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .ctrlMask(ctrlMask),
    .ctrlHold(ctrlHold), .ctrlWord(ctrlWord), .locked(locked)
  );

  tm_arb #(.NUM_PORTS(NUM_PORTS), .HOLD_W(HOLD_W)) u_arb (
    .clk(clk), .rstN(rstN), .eligible(inValid & ctrlMask),
    .holdField(ctrlHold), .fire(fire), .sel(sel)
  );

  tm_path #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_path (
    .sel(sel), .inData(inData), .outReady(outReady), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outSrc(outSrc), .fire(fire)
  );
endmodule

// File: rtl/tm_checker.sv
module tm_checker #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned ID_W      = 3,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned REG_W     = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PORTS-1:0] inValid,
  input logic [NUM_PORTS-1:0] inReady,
  input logic                 outValid,
  input logic                 outReady,
  input logic [ID_W-1:0]      outSrc,
  input logic [NUM_PORTS-1:0] ctrlMask,
  input logic [REG_W-1:0]     ctrlWord,
  input logic                 locked,
  input logic                 regWrEn,
  input logic [ADDR_W-1:0]    regAddr
);
  a_r10_ready_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(inReady));

  a_r5_ready_enabled: assert property (@(posedge clk) disable iff (!rstN)
    (inReady & ~ctrlMask) == '0);

  a_r9_beat_source: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |-> (inValid[outSrc] && inReady[outSrc]));

  a_r10_stall_stable: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !regWrEn && inValid[outSrc])
      |=> (outValid && outSrc == $past(outSrc)));

  a_r2_locked_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (locked && regWrEn && regAddr == '0) |=> $stable(ctrlWord));
endmodule

bind trace_merge tm_checker #(
  .NUM_PORTS(NUM_PORTS), .ID_W(ID_W), .ADDR_W(ADDR_W), .REG_W(REG_W)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outSrc(outSrc),
  .ctrlMask(ctrlMask), .ctrlWord(ctrlWord), .locked(locked),
  .regWrEn(regWrEn), .regAddr(regAddr)
);

// File: tb/trace_merge_bench.sv
module trace_merge_bench;
  localparam logic [31:0] KEY  = 32'hC5ACCE55;
  localparam logic [11:0] LOCK = 12'hFB0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  inValid = '0;
  logic [63:0] inData;
  logic [7:0]  inReady;
  logic        outValid;
  logic [7:0]  outData;
  logic [2:0]  outSrc;
  logic        outReady = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Bench model state
  logic [4:0] seq [8];
  logic [7:0] mMask = '0;
  int         mHold = 3;
  bit         mLocked = 1;
  int         mCur = 7;
  bit         mAct = 0;
  int         mCnt = 0;

  always #10 clk = ~clk;

  always_comb
    for (int p = 0; p < 8; p++) inData[p*8 +: 8] = {3'(p), seq[p]};

  trace_merge u_trace_merge (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outSrc(outSrc), .outReady(outReady),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int nextAbove(input logic [7:0] elig, input int last);
    for (int k = 1; k <= 8; k++) if (elig[(last + k) % 8]) return (last + k) % 8;
    return last;
  endfunction

  // One clock: drive, check at negedge against the model, update after the edge
  task automatic tick(input string tag, input logic [7:0] vm, input logic rdy,
                      input logic wr, input logic [11:0] a, input logic [31:0] d);
    logic [7:0] elig;
    bit keep, expValid;
    int pick;
    inValid = vm; outReady = rdy; regWrEn = wr; regAddr = a; regWrData = d;
    @(negedge clk);
    elig = vm & mMask;
    keep = mAct && elig[mCur];
    pick = keep ? mCur : nextAbove(elig, mCur);
    expValid = keep || (elig != 0);
    check(outValid == expValid, tag, "outValid", 32'(outValid), 32'(expValid));
    if (expValid) begin
      check(outSrc == 3'(pick), tag, "outSrc", 32'(outSrc), 32'(pick));
      check(outData == {3'(pick), seq[pick]}, tag, "outData", 32'(outData),
            32'({3'(pick), seq[pick]}));
    end
    check(inReady == ((expValid && rdy) ? 8'(1 << pick) : 8'h00), tag, "inReady",
          32'(inReady), 32'((expValid && rdy) ? (1 << pick) : 0));
    @(posedge clk);
    #1;
    if (expValid && rdy) begin
      int n;
      n = (keep ? mCnt : 0) + 1;
      if (n == mHold + 1) begin mAct = 0; mCnt = 0; end
      else begin mAct = 1; mCnt = n; end
      mCur = pick;
      seq[pick] = seq[pick] + 1;
    end else if (expValid) begin
      mCur = pick; mAct = 1;
      if (!keep) mCnt = 0;
    end else begin
      mAct = 0; mCnt = 0;
    end
    if (wr) begin
      if (a == LOCK) mLocked = (d != KEY);
      else if (a == 12'h000 && !mLocked) begin mMask = d[7:0]; mHold = int'(d[11:8]); end
    end
    regWrEn = 1'b0;
  endtask

  task automatic regWrite(input string tag, input logic [11:0] a, input logic [31:0] d);
    tick(tag, 8'h00, 1'b1, 1'b1, a, d);
  endtask

  task automatic readCheck(input string tag, input logic [11:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    check(regRdData == exp, tag, "regRdData", regRdData, exp);
  endtask

  task automatic run(input string tag, input logic [7:0] vm, input int n);
    for (int i = 0; i < n; i++) tick(tag, vm, 1'b1, 1'b0, 12'h000, '0);
  endtask

  task automatic t_reset;
    readCheck("R1", 12'h000, 32'h0000_0300);
    run("R5", 8'hFF, 4);
  endtask

  task automatic t_locked;
    regWrite("R2", 12'h000, 32'h0000_02FF);
    readCheck("R2", 12'h000, 32'h0000_0300);
    run("R2", 8'hFF, 3);
  endtask

  task automatic t_key;
    regWrite("R3", LOCK, KEY);
    regWrite("R4", 12'h000, 32'h0000_01A5);
    readCheck("R4", 12'h000, 32'h0000_01A5);
    readCheck("R4", 12'h004, 32'h0);
    readCheck("R4", LOCK, 32'h0);
    regWrite("R3", LOCK, 32'h0000_1234);
    regWrite("R3", 12'h000, 32'h0000_00FF);
    readCheck("R3", 12'h000, 32'h0000_01A5);
    regWrite("R3", LOCK, KEY);
  endtask

  task automatic t_hold;
    regWrite("R6", 12'h000, 32'h0000_02FF);
    run("R6", 8'hFF, 30);
    run("R6", 8'h00, 2);
  endtask

  task automatic t_order;
    regWrite("R7", 12'h000, 32'h0000_0091);
    run("R7", 8'hFF, 12);
    run("R5", 8'h6E, 4);
    run("R7", 8'h00, 1);
  endtask

  task automatic t_early;
    regWrite("R8", 12'h000, 32'h0000_07FF);
    run("R8", 8'h09, 3);
    run("R8", 8'h08, 3);
    run("R8", 8'h0C, 2);
    // clear enable of the granted port while it streams
    tick("R10", 8'h0C, 1'b1, 1'b1, 12'h000, 32'h0000_07F7);
    run("R8", 8'h0C, 4);
    run("R8", 8'h00, 1);
  endtask

  task automatic t_stall;
    regWrite("R10", 12'h000, 32'h0000_01FF);
    for (int i = 0; i < 12; i++) tick("R10", 8'h35, (i % 3) == 2, 1'b0, 12'h000, '0);
    run("R9", 8'hA6, 10);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
    summary();
  end

  initial begin
    for (int p = 0; p < 8; p++) seq[p] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_locked();
    t_key();
    t_hold();
    t_order();
    t_early();
    t_stall();
    summary();
  end
endmodule